// File: doc/BRIEF.md
# CAN / CAN-FD Frame Field Parser

The parser sits behind a bit destuffer. It takes one destuffed frame bit per strobe together with that bit's position in the frame, counted from 0 at start of frame. It decodes the fields of classic base frames, extended frames and FD base frames. The decoded fields are the identifier, the format flags, the length code, the payload length, the payload bytes, the checksum field, the acknowledge status, a set of format-error flags and an end-of-frame pulse.

The field positions after the identifier depend on the frame format. The identifier-extension bit at position 13 selects the format, and for base frames so does the flexible-format bit at position 14. Every position after the payload is derived from the decoded payload length. The parser returns the index of the last payload bit to the destuffer, which needs that index to know where stuffing stops. A bit is sampled on the edge where `bitValid` is high, and every output it affects is registered, so the new value appears in the following cycle. The parser does not check the checksum value, and it does not handle error frames, overload frames or bit-rate switching.

Top module: `can_field_parser`

## Requirements
- R1: A bit at position 0 starts a new frame. It clears every decoded field and every error flag. `errSof` is set when that bit is recessive (1).
- R2: Positions 1..11 carry the base identifier, most significant bit first. For a base frame, `frameId` shows it in bits [10:0] with zeros above. `errIdRec` is set when identifier bits 10..4 (positions 1..7) are all recessive.
- R3: Position 13 recessive marks an extended frame (`isExt`=1). Positions 14..31 then carry an 18-bit extension, most significant bit first, and `frameId` = base<<18 | extension.
- R4: In a base frame, position 14 recessive marks an FD frame (`isFd`=1). The 4-bit length code, most significant bit first, sits at positions 18..21 for FD frames, at 15..18 for classic base frames and at 35..38 for extended frames. It is shown on `dlcCode`.
- R5: A remote request is flagged on `isRemote`. In a classic base frame it is position 12 recessive; in an extended frame it is position 32 recessive. A remote frame has payload length 0 for any length code.
- R6: For FD frames, codes 0..8 give 0..8 bytes and codes 9..15 give 12, 16, 20, 24, 32, 48 and 64 bytes. For classic and extended frames the length is min(code, 8), and a code above 8 sets `errDlc`.
- R7: Payload bits follow the length code directly, most significant bit first within each byte. One cycle after the last bit of each byte, `byteValid` pulses with `byteData` and the byte's index (from 0) on `byteIdx`.
- R8: Before the length code is complete, `lastDataIdx` is all ones. From the cycle after the code's last bit until the next frame, it is the code's last position + 8 × payload length.
- R9: The checksum field follows the payload. It is 15 bits for non-FD frames, 17 bits for FD frames of up to 16 bytes and 21 bits above that. `crcVal` holds it right-aligned.
- R10: After the checksum come the checksum delimiter, the acknowledge slot, the acknowledge delimiter and 7 end bits. A dominant delimiter sets `errCrcDelim` or `errAckDelim`. A dominant end bit sets `errEof`. `ackOk` is 1 when the slot is dominant.
- R11: `frameDone` is high for exactly one cycle, the cycle after the last end bit. Error flags stay set until the next position-0 bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bitValid | input | 1 | A destuffed bit is presented this cycle |
| bitVal | input | 1 | Bit value, 0 dominant, 1 recessive |
| bitIdx | input | 10 | Position of the bit within the frame |
| lastDataIdx | output | 10 | Position of the last payload bit, all ones until known |
| frameId | output | 29 | Base or full extended identifier |
| isExt | output | 1 | Extended frame |
| isFd | output | 1 | FD frame |
| isRemote | output | 1 | Remote request frame |
| dlcCode | output | 4 | Received length code |
| payLen | output | 7 | Payload length in bytes |
| byteValid | output | 1 | Payload byte strobe |
| byteData | output | 8 | Payload byte |
| byteIdx | output | 6 | Index of the strobed byte |
| crcVal | output | 21 | Received checksum field, right-aligned |
| ackOk | output | 1 | Acknowledge slot was dominant |
| errSof | output | 1 | Start bit was recessive |
| errIdRec | output | 1 | Identifier bits 10..4 all recessive |
| errDlc | output | 1 | Non-FD length code above 8 |
| errCrcDelim | output | 1 | Checksum delimiter was dominant |
| errAckDelim | output | 1 | Acknowledge delimiter was dominant |
| errEof | output | 1 | A dominant end bit |
| frameDone | output | 1 | One-cycle pulse after the last end bit |

## Verification
Two events can fall on the same clock edge: the end-of-frame pulse falls, and the start bit of the next frame clears all decoded fields and error flags. Every frame in the sweep is sent with its start bit in the cycle directly after the previous frame's last end bit. So the previous frame's fields, flags and `frameDone` are judged in the one cycle between those two edges. The next cycle must then show `frameDone` low, cleared flags and the new start-bit error state. Idle gaps are placed after error frames to show that the flags persist until a start bit arrives.

// File: rtl/canfp_pkg.sv
package canfp_pkg;

  localparam int IDX_W  = 10;   // frame bit position width
  localparam int ID_W   = 29;   // full extended identifier
  localparam int BASE_W = 11;   // base identifier
  localparam int CRC_W  = 21;   // widest checksum field
  localparam int LEN_W  = 7;    // payload length 0..64
  localparam int BIDX_W = 6;    // payload byte index 0..63
  localparam int DLC_W  = 4;
  localparam int ERR_N  = 6;

  // per-bit strobes from the position decoder to the datapath
  typedef struct packed {
    logic              sof;
    logic              shId;
    logic              idLast;
    logic              capB12;
    logic              capIde;
    logic              capFdf;
    logic              capRtrExt;
    logic              shDlc;
    logic              dlcLast;
    logic              dataBit;
    logic              byteEnd;
    logic [BIDX_W-1:0] byteIdx;
    logic              shCrc;
    logic              crcDelim;
    logic              ackSlot;
    logic              ackDelim;
    logic              eofBit;
    logic              eofLast;
  } stb_t;

  function automatic logic [LEN_W-1:0] dlcToLen(input logic [DLC_W-1:0] code,
                                                 input logic fd);
    logic [LEN_W-1:0] len;
    len = LEN_W'(code);
    if (!fd) begin
      if (code > 4'd8) len = LEN_W'(8);
    end else begin
      case (code)
        4'd9:    len = LEN_W'(12);
        4'd10:   len = LEN_W'(16);
        4'd11:   len = LEN_W'(20);
        4'd12:   len = LEN_W'(24);
        4'd13:   len = LEN_W'(32);
        4'd14:   len = LEN_W'(48);
        4'd15:   len = LEN_W'(64);
        default: len = LEN_W'(code);
      endcase
    end
    return len;
  endfunction

endpackage

// File: rtl/canfp_ctrl.sv
module canfp_ctrl
  import canfp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bitValid,
  input  logic [IDX_W-1:0]    bitIdx,
  input  logic                isExt,
  input  logic                isFd,
  input  logic                dlcKnown,
  input  logic [LEN_W-1:0]    payLen,
  output stb_t                stb,
  output logic [IDX_W-1:0]    lastDataIdx
);

  logic [IDX_W-1:0] dlcStart, dlcEnd, lastData, crcLen, crcEnd;
  logic [IDX_W-1:0] posCrcDelim, posAck, posAckDelim, posEofLast, dataOff;

  // field layout derived from the decoded format and length
  always_comb begin
    if (isExt)      dlcStart = IDX_W'(35);
    else if (isFd)  dlcStart = IDX_W'(18);
    else            dlcStart = IDX_W'(15);
    dlcEnd   = dlcStart + IDX_W'(3);
    lastData = dlcEnd + IDX_W'({payLen, 3'b000});
    if (!isFd)                    crcLen = IDX_W'(15);
    else if (payLen > LEN_W'(16)) crcLen = IDX_W'(21);
    else                          crcLen = IDX_W'(17);
    crcEnd      = lastData + crcLen;
    posCrcDelim = crcEnd + IDX_W'(1);
    posAck      = crcEnd + IDX_W'(2);
    posAckDelim = crcEnd + IDX_W'(3);
    posEofLast  = crcEnd + IDX_W'(10);
    dataOff     = bitIdx - dlcEnd - IDX_W'(1);
  end

  assign lastDataIdx = dlcKnown ? lastData : '1;

  // position decoder
  always_comb begin
    stb = '0;
    if (bitValid) begin
      if (bitIdx == '0) begin
        stb.sof = 1'b1;
      end else if (bitIdx <= 11) begin
        stb.shId   = 1'b1;
        stb.idLast = (bitIdx == 11);
      end else if (bitIdx == 12) begin
        stb.capB12 = 1'b1;
      end else if (bitIdx == 13) begin
        stb.capIde = 1'b1;
      end else if (!dlcKnown) begin
        if (isExt && bitIdx <= 31) begin
          stb.shId = 1'b1;
        end else if (!isExt && bitIdx == 14) begin
          stb.capFdf = 1'b1;
        end else if (isExt && bitIdx == 32) begin
          stb.capRtrExt = 1'b1;
        end else if (bitIdx >= dlcStart && bitIdx <= dlcEnd) begin
          stb.shDlc   = 1'b1;
          stb.dlcLast = (bitIdx == dlcEnd);
        end
      end else begin
        if (bitIdx <= dlcEnd) begin
          stb.sof = 1'b0;
        end else if (bitIdx <= lastData) begin
          stb.dataBit = 1'b1;
          stb.byteEnd = (dataOff[2:0] == 3'b111);
          stb.byteIdx = BIDX_W'(dataOff >> 3);
        end else if (bitIdx <= crcEnd) begin
          stb.shCrc = 1'b1;
        end else if (bitIdx == posCrcDelim) begin
          stb.crcDelim = 1'b1;
        end else if (bitIdx == posAck) begin
          stb.ackSlot = 1'b1;
        end else if (bitIdx == posAckDelim) begin
          stb.ackDelim = 1'b1;
        end else if (bitIdx <= posEofLast) begin
          stb.eofBit  = 1'b1;
          stb.eofLast = (bitIdx == posEofLast);
        end
      end
    end
  end

  // at most one field claims a bit
  AST_ONE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.sof, stb.shId, stb.capB12, stb.capIde, stb.capFdf, stb.capRtrExt,
              stb.shDlc, stb.dataBit, stb.shCrc, stb.crcDelim, stb.ackSlot,
              stb.ackDelim, stb.eofBit})); // R4

  // once the length is known the reported boundary does not move within the frame
  AST_LASTDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dlcKnown && !stb.sof) |=> $stable(lastDataIdx)); // R8

endmodule

// File: rtl/canfp_dpath.sv
module canfp_dpath
  import canfp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bitVal,
  input  stb_t                stb,
  output logic                dlcKnown,
  output logic [ID_W-1:0]     frameId,
  output logic                isExt,
  output logic                isFd,
  output logic                isRemote,
  output logic [DLC_W-1:0]    dlcCode,
  output logic [LEN_W-1:0]    payLen,
  output logic                byteValid,
  output logic [7:0]          byteData,
  output logic [BIDX_W-1:0]   byteIdx,
  output logic [CRC_W-1:0]    crcVal,
  output logic                ackOk,
  output logic                errSof,
  output logic                errIdRec,
  output logic                errDlc,
  output logic                errCrcDelim,
  output logic                errAckDelim,
  output logic                errEof,
  output logic                frameDone
);

  logic [ID_W-1:0]  idSr;
  logic             bit12, rtrExt;
  logic [DLC_W-1:0] dlcSr;
  logic [6:0]       byteSr;
  logic [CRC_W-1:0] crcSr;
  logic [ERR_N-1:0] errVec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idSr <= '0; bit12 <= 1'b0; isExt <= 1'b0; isFd <= 1'b0; rtrExt <= 1'b0;
      dlcSr <= '0; dlcKnown <= 1'b0; byteSr <= '0; byteValid <= 1'b0;
      byteData <= '0; byteIdx <= '0; crcSr <= '0; ackOk <= 1'b0;
      errSof <= 1'b0; errIdRec <= 1'b0; errDlc <= 1'b0;
      errCrcDelim <= 1'b0; errAckDelim <= 1'b0; errEof <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      frameDone <= 1'b0;
      if (stb.sof) begin
        idSr <= '0; bit12 <= 1'b0; isExt <= 1'b0; isFd <= 1'b0; rtrExt <= 1'b0;
        dlcSr <= '0; dlcKnown <= 1'b0; byteSr <= '0; byteData <= '0;
        byteIdx <= '0; crcSr <= '0; ackOk <= 1'b0;
        errSof <= bitVal; errIdRec <= 1'b0; errDlc <= 1'b0;
        errCrcDelim <= 1'b0; errAckDelim <= 1'b0; errEof <= 1'b0;
      end
      if (stb.shId) begin
        idSr <= {idSr[ID_W-2:0], bitVal};
        if (stb.idLast && (&idSr[9:3])) errIdRec <= 1'b1;
      end
      if (stb.capB12)    bit12  <= bitVal;
      if (stb.capIde)    isExt  <= bitVal;
      if (stb.capFdf)    isFd   <= bitVal;
      if (stb.capRtrExt) rtrExt <= bitVal;
      if (stb.shDlc) begin
        dlcSr <= {dlcSr[DLC_W-2:0], bitVal};
        if (stb.dlcLast) begin
          dlcKnown <= 1'b1;
          if (!isFd && ({dlcSr[DLC_W-2:0], bitVal} > 4'd8)) errDlc <= 1'b1;
        end
      end
      if (stb.dataBit) begin
        byteSr <= {byteSr[5:0], bitVal};
        if (stb.byteEnd) begin
          byteValid <= 1'b1;
          byteData  <= {byteSr, bitVal};
          byteIdx   <= stb.byteIdx;
        end
      end
      if (stb.shCrc)                 crcSr <= {crcSr[CRC_W-2:0], bitVal};
      if (stb.crcDelim && !bitVal)   errCrcDelim <= 1'b1;
      if (stb.ackSlot)               ackOk <= !bitVal;
      if (stb.ackDelim && !bitVal)   errAckDelim <= 1'b1;
      if (stb.eofBit && !bitVal)     errEof <= 1'b1;
      if (stb.eofLast)               frameDone <= 1'b1;
    end
  end

  assign isRemote = isExt ? rtrExt : (!isFd && bit12);
  assign payLen   = isRemote ? '0 : dlcToLen(dlcSr, isFd);
  assign dlcCode  = dlcSr;
  assign crcVal   = crcSr;
  assign frameId  = isExt ? idSr : {{(ID_W-BASE_W){1'b0}}, idSr[BASE_W-1:0]};
  assign errVec   = {errSof, errIdRec, errDlc, errCrcDelim, errAckDelim, errEof};

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |=> !frameDone); // R11

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.sof |=> ((errVec & $past(errVec)) == $past(errVec))); // R11

  AST_BYTE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    byteValid |-> (LEN_W'(byteIdx) < payLen)); // R7

  AST_CLASSIC_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dlcKnown && !isFd) |-> (payLen <= LEN_W'(8))); // R6

  AST_REMOTE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    isRemote |-> (payLen == '0)); // R5

endmodule

// File: rtl/can_field_parser.sv
module can_field_parser
  import canfp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bitValid,
  input  logic                bitVal,
  input  logic [IDX_W-1:0]    bitIdx,
  output logic [IDX_W-1:0]    lastDataIdx,
  output logic [ID_W-1:0]     frameId,
  output logic                isExt,
  output logic                isFd,
  output logic                isRemote,
  output logic [DLC_W-1:0]    dlcCode,
  output logic [LEN_W-1:0]    payLen,
  output logic                byteValid,
  output logic [7:0]          byteData,
  output logic [BIDX_W-1:0]   byteIdx,
  output logic [CRC_W-1:0]    crcVal,
  output logic                ackOk,
  output logic                errSof,
  output logic                errIdRec,
  output logic                errDlc,
  output logic                errCrcDelim,
  output logic                errAckDelim,
  output logic                errEof,
  output logic                frameDone
);

  stb_t stb;
  logic dlcKnown;

  canfp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .bitValid(bitValid), .bitIdx(bitIdx),
    .isExt(isExt), .isFd(isFd), .dlcKnown(dlcKnown), .payLen(payLen),
    .stb(stb), .lastDataIdx(lastDataIdx)
  );

  canfp_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .bitVal(bitVal), .stb(stb),
    .dlcKnown(dlcKnown), .frameId(frameId), .isExt(isExt), .isFd(isFd),
    .isRemote(isRemote), .dlcCode(dlcCode), .payLen(payLen),
    .byteValid(byteValid), .byteData(byteData), .byteIdx(byteIdx),
    .crcVal(crcVal), .ackOk(ackOk), .errSof(errSof), .errIdRec(errIdRec),
    .errDlc(errDlc), .errCrcDelim(errCrcDelim), .errAckDelim(errAckDelim),
    .errEof(errEof), .frameDone(frameDone)
  );

endmodule

// File: tb/can_field_parser_bench.sv
`timescale 1ns/1ps
module can_field_parser_bench;
  import canfp_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, bitValid, bitVal;
  logic [IDX_W-1:0] bitIdx, lastDataIdx;
  logic [ID_W-1:0] frameId;
  logic isExt, isFd, isRemote, byteValid, ackOk, frameDone;
  logic errSof, errIdRec, errDlc, errCrcDelim, errAckDelim, errEof;
  logic [3:0] dlcCode;
  logic [LEN_W-1:0] payLen;
  logic [7:0] byteData;
  logic [BIDX_W-1:0] byteIdx;
  logic [CRC_W-1:0] crcVal;

  can_field_parser u_can_field_parser (.*);

  int vecs = 0, bad = 0;
  logic [ID_W-1:0] eId;
  logic eExt, eFd, eRem, eAck, pending;
  logic [3:0] eDlc;
  int eLen, seed, byteCnt;
  logic [CRC_W-1:0] eCrc;
  logic [5:0] eErr;
  logic fb [0:1023];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int lenOf(bit fd, bit rtr, int d);
    if (rtr) return 0;
    if (!fd) return (d > 8) ? 8 : d;
    if (d <= 8) return d;
    if (d <= 12) return 8 + 4 * (d - 8);
    if (d == 13) return 32;
    if (d == 14) return 48;
    return 64;
  endfunction

  function automatic logic [7:0] payByte(int s, int k);
    return 8'((k * 37 + s * 11 + 5) ^ (k >> 1));
  endfunction

  always @(negedge clk) begin
    if (rst_n && byteValid) begin
      chk("R7", "byteIdx", 32'(byteIdx), 32'(byteCnt));
      chk("R7", "byteData", 32'(byteData), 32'(payByte(seed, byteCnt)));
      byteCnt++;
    end
  end

  task automatic checkErrs(string req);
    chk(req, "errSof", 32'(errSof), 32'(eErr[5]));
    chk(req, "errIdRec", 32'(errIdRec), 32'(eErr[4]));
    chk(req, "errDlc", 32'(errDlc), 32'(eErr[3]));
    chk(req, "errCrcDelim", 32'(errCrcDelim), 32'(eErr[2]));
    chk(req, "errAckDelim", 32'(errAckDelim), 32'(eErr[1]));
    chk(req, "errEof", 32'(errEof), 32'(eErr[0]));
  endtask

  task automatic checkPending();
    if (pending) begin
      chk("R11", "frameDone", 32'(frameDone), 32'd1);
      chk("R2_R3", "frameId", 32'(frameId), 32'(eId));
      chk("R3", "isExt", 32'(isExt), 32'(eExt));
      chk("R4", "isFd", 32'(isFd), 32'(eFd));
      chk("R4", "dlcCode", 32'(dlcCode), 32'(eDlc));
      chk("R5", "isRemote", 32'(isRemote), 32'(eRem));
      chk("R6", "payLen", 32'(payLen), 32'(eLen));
      chk("R7", "byteCount", 32'(byteCnt), 32'(eLen));
      chk("R9", "crcVal", 32'(crcVal), 32'(eCrc));
      chk("R10", "ackOk", 32'(ackOk), 32'(eAck));
      checkErrs("R10");
      pending = 1'b0;
    end
  endtask

  task automatic sendFrame(bit ext, bit fd, bit rtr, logic [28:0] id, int d, int s,
                           logic [20:0] crc, bit sofBad, bit crcDBad, bit nack,
                           bit ackDBad, bit eofBad);
    int n, p, dlcS, len, clen;
    logic [10:0] baseId;
    baseId = ext ? id[28:18] : id[10:0];
    len = lenOf(fd, rtr, d);
    clen = !fd ? 15 : (len > 16 ? 21 : 17);
    fb[0] = sofBad;
    for (int i = 0; i < 11; i++) fb[1 + i] = baseId[10 - i];
    fb[12] = ext ? 1'b1 : (fd ? 1'b0 : rtr);
    fb[13] = ext;
    if (!ext) begin
      fb[14] = fd;
      if (fd) begin fb[15] = 1'b0; fb[16] = 1'b1; fb[17] = 1'b0; end
      dlcS = fd ? 18 : 15;
    end else begin
      for (int i = 0; i < 18; i++) fb[14 + i] = id[17 - i];
      fb[32] = rtr; fb[33] = 1'b0; fb[34] = 1'b0;
      dlcS = 35;
    end
    for (int i = 0; i < 4; i++) fb[dlcS + i] = d[3 - i];
    p = dlcS + 4;
    for (int k = 0; k < len; k++) begin
      logic [7:0] b;
      b = payByte(s, k);
      for (int i = 0; i < 8; i++) fb[p++] = b[7 - i];
    end
    for (int i = 0; i < clen; i++) fb[p++] = crc[clen - 1 - i];
    fb[p++] = !crcDBad;
    fb[p++] = nack;
    fb[p++] = !ackDBad;
    for (int i = 0; i < 7; i++) fb[p++] = !(eofBad && i == 3);
    n = p;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) begin
        checkPending();
        eId = ext ? id : {18'd0, id[10:0]};
        eExt = ext; eFd = fd; eRem = rtr; eDlc = 4'(d); eLen = len;
        eCrc = crc & ((21'd1 << clen) - 21'd1);
        eAck = !nack;
        eErr = {sofBad, (baseId[10:4] == 7'h7f), (!fd && d > 8), crcDBad, ackDBad, eofBad};
        byteCnt = 0; seed = s;
      end
      if (i == 1) begin
        chk("R11", "frameDone low after pulse", 32'(frameDone), 32'd0);
        chk("R1", "errSof at start", 32'(errSof), 32'(sofBad));
        chk("R1", "errEof cleared by start", 32'(errEof), 32'd0);
        chk("R1", "errCrcDelim cleared by start", 32'(errCrcDelim), 32'd0);
      end
      if (i == dlcS + 3)
        chk("R8", "lastDataIdx before code", 32'(lastDataIdx), 32'h3ff);
      if (i == dlcS + 4)
        chk("R8", "lastDataIdx", 32'(lastDataIdx), 32'(dlcS + 3 + 8 * len));
      bitValid = 1'b1; bitVal = fb[i]; bitIdx = IDX_W'(i);
    end
    pending = 1'b1;
  endtask

  task automatic idle(int k);
    @(negedge clk);
    checkPending();
    bitValid = 1'b0; bitVal = 1'b1; bitIdx = '0;
    repeat (k) @(negedge clk);
    chk("R11", "frameDone after gap", 32'(frameDone), 32'd0);
    checkErrs("R11");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    pending = 1'b0; byteCnt = 0; seed = 0;
    rst_n = 1'b0; bitValid = 1'b0; bitVal = 1'b1; bitIdx = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "reset lastDataIdx", 32'(lastDataIdx), 32'h3ff);
    chk("R11", "reset frameDone", 32'(frameDone), 32'd0);
    chk("R7", "reset byteValid", 32'(byteValid), 32'd0);
    chk("R1", "reset errSof", 32'(errSof), 32'd0);
    chk("R6", "reset payLen", 32'(payLen), 32'd0);

    for (int d = 0; d < 16; d++)
      sendFrame(1'b0, 1'b0, 1'b0, 29'((d * 97 + 3) & 11'h3ff), d, d, 21'(d * 4099 + 7),
                1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int d = 0; d < 16; d++)
      sendFrame(1'b0, 1'b1, 1'b0, 29'((d * 131 + 9) & 11'h5ff), d, d + 20,
                21'(d * 77777 + 1), 1'b0, 1'b0, d[0], 1'b0, 1'b0);
    for (int d = 0; d < 16; d++)
      sendFrame(1'b1, 1'b0, 1'b0, 29'(d * 32'h0123_4567 + 5), d, d + 40,
                21'(d * 3333 + 2), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    sendFrame(1'b0, 1'b0, 1'b1, 29'h123, 3, 60, 21'h1abc, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    sendFrame(1'b1, 1'b0, 1'b1, 29'h1abc_def0, 12, 61, 21'h2aaa, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    sendFrame(1'b0, 1'b0, 1'b0, 29'h7f5, 2, 62, 21'h0f0f, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    sendFrame(1'b0, 1'b0, 1'b0, 29'h045, 1, 63, 21'h1234, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    idle(5);
    sendFrame(1'b1, 1'b0, 1'b0, 29'h0fe0_0001, 8, 64, 21'h7777, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    idle(7);
    sendFrame(1'b0, 1'b1, 1'b0, 29'h3c3, 15, 65, 21'h15_5555, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    sendFrame(1'b0, 1'b0, 1'b0, 29'h001, 0, 66, 21'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule